// File: doc/BRIEF.md
# Framed Synchronous Serial Port with Loopback Test Modes

This block moves 16-bit words over a synchronous serial link. The receive bit clock is the only clock in the unit, and the parallel register port runs on that same clock. A one-cycle frame-sync pulse on `fs_i` opens a frame. A fixed number of words then follow back to back, most significant bit first, and the link goes idle until the next pulse. Each word that arrives is latched into a receive register and raises a sticky interrupt request, which a read strobe clears. The transmit register is copied into the serializer at the start of every word, so an unchanged register is sent again.

A two-bit test field picks the operating mode:

- **Normal:** the line runs as described above.
- **Remote echo:** the incoming line is passed straight out on the outgoing line, and the receive register and interrupt are left untouched. This lets the far end test the medium.
- **Local loop:** the serializer output is fed into the deserializer inside the block. A written word comes back in the receive register while the outgoing pin stays low.

A new test field value is taken only at the next frame-sync, so a word already in flight keeps its mode.

Top module: `ssp_serial_port`

## Requirements
- R1: After a frame-sync edge, the next 16 rising edges sample one word from the incoming line, bit 15 first and bit 0 last. The word appears on `rd_data_o` after the edge that samples bit 0.
- R2: A frame holds WORDS_PER_FRAME words (default 4) with no gap between them. After the last word the port is idle until the next frame-sync, and in normal mode `sd_o` is low while idle.
- R3: The transmit register is copied into the serializer at the frame-sync edge and at the end of each word that is not the last. Bit 15 is driven in the cycle after the load, and one bit is driven per cycle. A word whose register was not rewritten is sent again. A write during a word shows up in the next word.
- R4: In normal and local loop modes, each completed word sets `irq_o`. It stays set until a cycle with `rd_en_i` high, after which it is low.
- R5: The test field is decoded as follows: upper bit 0 (values 00 and 01) selects normal, 10 selects remote echo, and 11 selects local loop.
- R6: In remote echo, `sd_o` follows `sd_i` within the same cycle. The receive register does not change and `irq_o` does not rise.
- R7: In local loop, the deserializer takes the serializer's own output, so each word received equals the transmit register that was loaded. `sd_o` is held low and `sd_i` is ignored.
- R8: The test field is sampled only at a frame-sync edge. A change made in the middle of a frame leaves the rest of that frame in the old mode.
- R9: After reset, `rd_data_o` is 0, `irq_o` is 0, `sd_o` is 0, the transmit register is 0 and the mode is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock; clocks the whole unit |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_i | input | 1 | Frame-sync pulse, active high, one cycle wide |
| sd_i | input | 1 | Incoming serial data |
| sd_o | output | 1 | Outgoing serial data |
| test_mode_i | input | 2 | Test-mode field, taken at frame-sync |
| wr_en_i | input | 1 | Write strobe for the transmit register |
| wr_data_i | input | 16 | Transmit word to store |
| rd_en_i | input | 1 | Read strobe; clears the interrupt request |
| rd_data_o | output | 16 | Last received word |
| irq_o | output | 1 | Sticky receive interrupt request |

## Verification
A bit counter that is off by one shifts every received word by a bit. The error shows at `rd_data_o` on the first completed word, about 17 cycles after frame-sync. A wrong transmit load point shows on `sd_o` during the very next word. A mode register that updates outside frame-sync only becomes visible in the words that follow inside the same frame, so the bench changes the field mid-frame and checks those later words. Leaking receive side effects in remote echo stay hidden until a read, so the receive register and the interrupt are checked after every echoed word.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_REMOTE = 2'd1,
    MODE_LOCAL  = 2'd2
  } ssp_mode_e;

  // Upper field bit clear means normal; otherwise the lower bit picks the loop.
  function automatic ssp_mode_e decode_mode(input logic [1:0] field);
    if (!field[1]) return MODE_NORMAL;
    return field[0] ? MODE_LOCAL : MODE_REMOTE;
  endfunction

  // Receive side effects are allowed in every mode except remote echo.
  function automatic logic mode_captures(input ssp_mode_e m);
    return (m != MODE_REMOTE);
  endfunction

endpackage

// File: rtl/ssp_frame_ctrl.sv
module ssp_frame_ctrl
  import ssp_pkg::*;
#(
  parameter int WORD_W          = 16,
  parameter int WORDS_PER_FRAME = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fs_i,
  input  logic [1:0] mode_field_i,
  output logic       active_o,
  output logic       word_start_o,
  output logic       word_end_o,
  output ssp_mode_e  mode_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam int IDX_W = (WORDS_PER_FRAME > 1) ? $clog2(WORDS_PER_FRAME) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(WORDS_PER_FRAME - 1);

  logic [CNT_W-1:0] bit_cnt;
  logic [IDX_W-1:0] word_idx;
  logic             active_q;
  ssp_mode_e        mode_q;
  logic             last_word;
  logic             frame_done;

  assign last_word    = (word_idx == LAST_WORD);
  assign word_end_o   = active_q && (bit_cnt == LAST_BIT);
  assign frame_done   = word_end_o && last_word;
  assign word_start_o = fs_i || (word_end_o && !last_word);
  assign active_o     = active_q;
  assign mode_o       = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      bit_cnt  <= '0;
      word_idx <= '0;
      mode_q   <= MODE_NORMAL;
    end else if (fs_i) begin
      active_q <= 1'b1;
      bit_cnt  <= '0;
      word_idx <= '0;
      mode_q   <= decode_mode(mode_field_i);
    end else if (active_q) begin
      if (word_end_o) begin
        bit_cnt <= '0;
        if (last_word) active_q <= 1'b0;
        else           word_idx <= word_idx + 1'b1;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_i |=> $stable(mode_o));

  // R2
  frame_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !fs_i) |=> !active_o);

endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              load_i,
  input  logic              active_i,
  output logic              ser_o
);
  logic [WORD_W-1:0] tx_reg;
  logic [WORD_W-1:0] tx_shift;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_reg   <= '0;
      tx_shift <= '0;
    end else begin
      if (wr_en_i) tx_reg <= wr_data_i;
      if (load_i)        tx_shift <= tx_reg;
      else if (active_i) tx_shift <= {tx_shift[WORD_W-2:0], 1'b0};
    end
  end

  assign ser_o = active_i && tx_shift[WORD_W-1];

  // R3
  tx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (ser_o == $past(tx_reg[WORD_W-1])));

endmodule

// File: rtl/ssp_rx.sv
module ssp_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic              bit_i,
  input  logic              word_end_i,
  input  logic              capture_en_i,
  input  logic              rd_clr_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              irq_o
);
  logic [WORD_W-2:0] rx_shift;
  logic [WORD_W-1:0] rx_data_q;
  logic              irq_q;
  logic              word_done;

  assign word_done = word_end_i && capture_en_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_shift  <= '0;
      rx_data_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      if (sample_i) rx_shift <= {rx_shift[WORD_W-3:0], bit_i};
      if (word_done) begin
        rx_data_q <= {rx_shift, bit_i};
        irq_q     <= 1'b1;
      end else if (rd_clr_i) begin
        irq_q <= 1'b0;
      end
    end
  end

  assign rx_data_o = rx_data_q;
  assign irq_o     = irq_q;

  // R6
  rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_en_i |=> ($stable(rx_data_o) && !$rose(irq_o)));

  // R4
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> irq_o);

  // R4
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_i && !word_done) |=> !irq_o);

endmodule

// File: rtl/ssp_serial_port.sv
module ssp_serial_port
  import ssp_pkg::*;
#(
  parameter int WORD_W          = 16,
  parameter int WORDS_PER_FRAME = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_i,
  input  logic              sd_i,
  output logic              sd_o,
  input  logic [1:0]        test_mode_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic      active;
  logic      word_start;
  logic      word_end;
  ssp_mode_e mode;
  logic      tx_ser;
  logic      rx_bit;
  logic      capture_en;

  ssp_frame_ctrl #(.WORD_W(WORD_W), .WORDS_PER_FRAME(WORDS_PER_FRAME)) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .fs_i         (fs_i),
    .mode_field_i (test_mode_i),
    .active_o     (active),
    .word_start_o (word_start),
    .word_end_o   (word_end),
    .mode_o       (mode)
  );

  ssp_tx #(.WORD_W(WORD_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .load_i    (word_start),
    .active_i  (active),
    .ser_o     (tx_ser)
  );

  assign capture_en = mode_captures(mode);
  assign rx_bit     = (mode == MODE_LOCAL) ? tx_ser : sd_i;

  always_comb begin
    unique case (mode)
      MODE_REMOTE: sd_o = sd_i;
      MODE_LOCAL:  sd_o = 1'b0;
      default:     sd_o = tx_ser;
    endcase
  end

  ssp_rx #(.WORD_W(WORD_W)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_i     (active),
    .bit_i        (rx_bit),
    .word_end_i   (word_end),
    .capture_en_i (capture_en),
    .rd_clr_i     (rd_en_i),
    .rx_data_o    (rd_data_o),
    .irq_o        (irq_o)
  );

endmodule

// File: tb/ssp_serial_port_test.sv
`timescale 1ns/1ps
module ssp_serial_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs = 1'b0, sd_in = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  tmode = 2'b00;
  logic [15:0] wr_data = '0;
  logic        sd_out, irq;
  logic [15:0] rd_data;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  ssp_serial_port uut (
    .clk(clk), .rst_n(rst_n), .fs_i(fs), .sd_i(sd_in), .sd_o(sd_out),
    .test_mode_i(tmode), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .irq_o(irq)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_tx(input logic [15:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic read_clr();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic fs_pulse();
    @(negedge clk); fs = 1'b1; sd_in = 1'b0;
  endtask

  // One word: line_out is sd_o before each bit is driven, echo_out just after.
  // prev_* are the port values left by the previous word's final edge.
  task automatic xfer_word(input logic [15:0] din, input bit wr, input logic [15:0] wv,
                           output logic [15:0] line_out, output logic [15:0] echo_out,
                           output logic [15:0] prev_rx, output logic prev_irq);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      if (i == 15) begin prev_rx = rd_data; prev_irq = irq; end
      fs = 1'b0;
      line_out[i] = sd_out;
      wr_en = 1'b0;
      if (wr && i == 8) begin wr_en = 1'b1; wr_data = wv; end
      sd_in = din[i];
      #1 echo_out[i] = sd_out;
    end
  endtask

  task automatic idle(output logic [15:0] rx, output logic ir, output logic so);
    @(negedge clk); fs = 1'b0; sd_in = 1'b0; wr_en = 1'b0;
    rx = rd_data; ir = irq; so = sd_out;
  endtask

  task automatic t_reset();
    chk("R9", "rx data after reset", rd_data, 16'h0000);
    chk("R9", "irq after reset", {15'd0, irq}, 16'd0);
    chk("R9", "sd_o after reset", {15'd0, sd_out}, 16'd0);
  endtask

  task automatic t_normal();
    logic [15:0] din [4] = '{16'h8001, 16'h1234, 16'hFEDC, 16'h0F0F};
    logic [15:0] expo [4] = '{16'hA5C3, 16'hA5C3, 16'h3C5A, 16'h3C5A};
    logic [15:0] lo, eo, pr, rx; logic pi, ir, so;
    tmode = 2'b00;
    wr_tx(16'hA5C3);
    fs_pulse();
    for (int k = 0; k < 4; k++) begin
      xfer_word(din[k], k == 1, 16'h3C5A, lo, eo, pr, pi);
      chk("R3", $sformatf("normal tx word %0d", k), lo, expo[k]);
      if (k > 0) begin
        chk("R1", $sformatf("normal rx word %0d", k-1), pr, din[k-1]);
        chk("R4", $sformatf("irq after word %0d", k-1), {15'd0, pi}, 16'd1);
      end
    end
    idle(rx, ir, so);
    chk("R1", "normal rx last word", rx, din[3]);
    idle(rx, ir, so);
    chk("R2", "sd_o low after frame", {15'd0, so}, 16'd0);
    chk("R4", "irq sticky while idle", {15'd0, ir}, 16'd1);
  endtask

  task automatic t_read();
    logic [15:0] rx; logic ir, so;
    read_clr();
    idle(rx, ir, so);
    chk("R4", "irq cleared by read", {15'd0, ir}, 16'd0);
    chk("R4", "rx data kept after read", rx, 16'h0F0F);
  endtask

  task automatic t_remote();
    logic [15:0] din [4] = '{16'h9A3C, 16'h0001, 16'hF00D, 16'h7E81};
    logic [15:0] lo, eo, pr, rx; logic pi, ir, so;
    tmode = 2'b10;
    wr_tx(16'h5555);
    fs_pulse();
    for (int k = 0; k < 4; k++) begin
      xfer_word(din[k], 1'b0, 16'h0, lo, eo, pr, pi);
      chk("R6", $sformatf("remote echo word %0d", k), eo, din[k]);
      chk("R6", $sformatf("remote rx untouched %0d", k), pr, 16'h0F0F);
      chk("R6", $sformatf("remote irq quiet %0d", k), {15'd0, pi}, 16'd0);
    end
    idle(rx, ir, so);
    chk("R6", "remote rx untouched end", rx, 16'h0F0F);
    chk("R5", "field 10 gave no irq", {15'd0, ir}, 16'd0);
  endtask

  task automatic t_switch();
    logic [15:0] din [4] = '{16'h1111, 16'h2D4B, 16'hC3E1, 16'h6006};
    logic [15:0] lo, eo, pr, rx; logic pi, ir, so;
    tmode = 2'b00;
    fs_pulse();
    for (int k = 0; k < 4; k++) begin
      xfer_word(din[k], 1'b0, 16'h0, lo, eo, pr, pi);
      if (k == 0) tmode = 2'b11;
      if (k > 1) chk("R8", $sformatf("mid-frame change ignored %0d", k-1), pr, din[k-1]);
    end
    idle(rx, ir, so);
    chk("R8", "old mode kept to frame end", rx, din[3]);
    read_clr();
  endtask

  task automatic t_local();
    logic [15:0] lo, eo, pr, rx; logic pi, ir, so;
    wr_tx(16'hBEEF);
    fs_pulse();
    for (int k = 0; k < 4; k++) begin
      xfer_word(16'h4A52 ^ 16'(k), 1'b0, 16'h0, lo, eo, pr, pi);
      chk("R7", $sformatf("local sd_o low %0d", k), lo, 16'h0000);
      if (k > 0) begin
        chk("R7", $sformatf("local loop word %0d", k-1), pr, 16'hBEEF);
        chk("R4", $sformatf("local irq %0d", k-1), {15'd0, pi}, 16'd1);
      end
    end
    idle(rx, ir, so);
    chk("R7", "local loop last word", rx, 16'hBEEF);
    read_clr();
  endtask

  task automatic t_field01();
    logic [15:0] lo, eo, pr, rx; logic pi, ir, so;
    tmode = 2'b01;
    wr_tx(16'h1357);
    fs_pulse();
    for (int k = 0; k < 4; k++) begin
      xfer_word(16'h6A95, 1'b0, 16'h0, lo, eo, pr, pi);
      if (k == 0) chk("R5", "field 01 transmits", lo, 16'h1357);
    end
    idle(rx, ir, so);
    chk("R5", "field 01 receives", rx, 16'h6A95);
    chk("R5", "field 01 irq", {15'd0, ir}, 16'd1);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_read();
    t_remote();
    t_switch();
    t_local();
    t_field01();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule